// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block takes a wide bank of GPIO pad inputs and presents eight interrupt request lines to a downstream interrupt controller. Each output channel picks one pad through its own wide selector. It can invert that pad and can pass it through a programmable glitch filter. It then delivers a request that is always active-high. Depending on the channel's mode, the request is either a level or a single-cycle pulse. Active-low levels and falling edges are therefore turned into a form the downstream controller accepts without extra configuration.

All pads pass through a two-flop synchroniser before selection. A small word-addressed register file holds the per-channel settings. These are an 8-bit pad index, an edge-mode flag, a both-edges flag, an inversion flag and a 4-bit filter length. When a channel's pad index or mode is rewritten, the block reloads that channel's edge history, so reprogramming never fires a false request.

Top module: `gim_irq_mux`

## Requirements
- R1: After reset every register reads zero and, with all pads low, every request output is low.
- R2: Word 0 holds the mode flags, word 1 the pad indices of channels 0..3, word 2 those of channels 4..7 and word 3 the filter lengths. Each reads back what was last written. Bits 31..24 of word 0 read zero. Words 4..7 read zero and ignore writes. A write takes effect on the next clock.
- R3: The pad index of channel n sits at bit 8*(n mod 4) of word 1 (n<4) or word 2 (n>=4). An index at or above NUM_PADS selects a constant 0.
- R4: With bit n of word 0 clear, the channel is in level mode and request n is high while the selected pad, inverted when bit 16+n is set, is high. A pad change appears on the request three clocks later when the filter length is zero.
- R5: With bit n of word 0 set, request n is a one-cycle pulse on each 0-to-1 change of the conditioned input. Together with the inversion bit 16+n, this detects falling edges of the pad.
- R6: With bit 8+n of word 0 set, request n pulses for one cycle on every change of the selected pad, whatever bits n and 16+n hold.
- R7: The filter length k of channel n sits at bits 4n+3..4n of word 3. For k>0 the conditioned input must differ from the channel's state for 4k consecutive cycles before the state follows it, so a pad change appears 2+4k clocks later. Shorter disturbances are ignored.
- R8: Writing a new pad index or new mode flags for a channel produces no request pulse on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_o | output | 8 | Active-high interrupt requests, one per channel |

## Verification
On every cycle, the assertions check several properties. Unmapped words read as zero. An edge-mode pulse never lasts longer than one cycle. A channel routed to a nonexistent pad stays quiet in level mode. The cycle after a history reload carries no pulse. The bench alone can show the rest. It sweeps every channel across every pad index, including indices past the implemented pads. It measures the exact synchroniser and filter latencies, and it shows that falling and both-edge detection fire at the right moment. It also shows that a filter disturbance one cycle too short is dropped.

// File: rtl/gim_pkg.sv
package gim_pkg;
    localparam int NUM_CH  = 8;
    localparam int SEL_W   = 8;
    localparam int PAD_MAX = 1 << SEL_W;
    localparam int FILT_W  = 4;
    localparam int CNT_W   = FILT_W + 2;

    localparam logic [2:0] W_MODE  = 3'd0;
    localparam logic [2:0] W_SELLO = 3'd1;
    localparam logic [2:0] W_SELHI = 3'd2;
    localparam logic [2:0] W_FILT  = 3'd3;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              edge_en;
        logic              both_en;
        logic              inv_en;
        logic [FILT_W-1:0] filt;
    } ch_cfg_t;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/gim_regs.sv
module gim_regs
    import gim_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [31:0]                  wdata_i,
    output logic [31:0]                  rdata_o,
    output ch_cfg_t [NUM_CH-1:0]         cfg_o,
    output logic [NUM_CH-1:0]            reload_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] edge_m;
        logic [NUM_CH-1:0] both_m;
        logic [NUM_CH-1:0] inv_m;
        logic [31:0]       sel_lo;
        logic [31:0]       sel_hi;
        logic [31:0]       filt;
        logic [NUM_CH-1:0] reload;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.reload = '0;
        if (wr_i) begin
            case (addr_i)
                ADDR_W'(W_MODE): begin
                    r_d.edge_m = wdata_i[7:0];
                    r_d.both_m = wdata_i[15:8];
                    r_d.inv_m  = wdata_i[23:16];
                    r_d.reload = (r_q.edge_m ^ wdata_i[7:0])
                               | (r_q.both_m ^ wdata_i[15:8])
                               | (r_q.inv_m  ^ wdata_i[23:16]);
                end
                ADDR_W'(W_SELLO): begin
                    r_d.sel_lo = wdata_i;
                    for (int c = 0; c < 4; c++)
                        r_d.reload[c] = |(r_q.sel_lo[c*8 +: 8] ^ wdata_i[c*8 +: 8]);
                end
                ADDR_W'(W_SELHI): begin
                    r_d.sel_hi = wdata_i;
                    for (int c = 0; c < 4; c++)
                        r_d.reload[c+4] = |(r_q.sel_hi[c*8 +: 8] ^ wdata_i[c*8 +: 8]);
                end
                ADDR_W'(W_FILT): r_d.filt = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(W_MODE):  rdata_o = {8'h00, r_q.inv_m, r_q.both_m, r_q.edge_m};
            ADDR_W'(W_SELLO): rdata_o = r_q.sel_lo;
            ADDR_W'(W_SELHI): rdata_o = r_q.sel_hi;
            ADDR_W'(W_FILT):  rdata_o = r_q.filt;
            default:          rdata_o = '0;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        if (c < 4) begin : g_lo
            assign cfg_o[c].sel = r_q.sel_lo[c*8 +: 8];
        end else begin : g_hi
            assign cfg_o[c].sel = r_q.sel_hi[(c-4)*8 +: 8];
        end
        assign cfg_o[c].edge_en = r_q.edge_m[c];
        assign cfg_o[c].both_en = r_q.both_m[c];
        assign cfg_o[c].inv_en  = r_q.inv_m[c];
        assign cfg_o[c].filt    = r_q.filt[c*4 +: 4];
    end

    assign reload_o = r_q.reload;
endmodule

// File: rtl/gim_channel.sv
module gim_channel
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads_i,
    input  ch_cfg_t             cfg_i,
    input  logic                reload_i,
    output logic                irq_o
);
    typedef struct packed {
        logic             state;
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t ch_d, ch_q;

    logic [PAD_MAX-1:0] pad_ext;
    logic               picked;
    logic               cond;
    logic [CNT_W-1:0]   lim_m1;

    assign pad_ext = PAD_MAX'(pads_i);

    always_comb begin
        picked = (32'(cfg_i.sel) < NUM_PADS) ? pad_ext[cfg_i.sel] : 1'b0;
        cond   = picked ^ (cfg_i.inv_en & ~cfg_i.both_en);
        lim_m1 = (cfg_i.filt == '0) ? '0 : ({cfg_i.filt, 2'b00} - CNT_W'(1));
    end

    always_comb begin
        ch_d      = ch_q;
        ch_d.prev = ch_q.state;
        if (reload_i) begin
            ch_d.state = cond;
            ch_d.prev  = cond;
            ch_d.cnt   = '0;
        end else if (cond == ch_q.state) begin
            ch_d.cnt = '0;
        end else if (ch_q.cnt == lim_m1) begin
            ch_d.state = cond;
            ch_d.cnt   = '0;
        end else begin
            ch_d.cnt = ch_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    always_comb begin
        if (cfg_i.both_en)      irq_o = ch_q.state ^ ch_q.prev;
        else if (cfg_i.edge_en) irq_o = ch_q.state & ~ch_q.prev;
        else                    irq_o = ch_q.state;
    end
endmodule

// File: rtl/gim_irq_mux.sv
module gim_irq_mux
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_CH-1:0]   irq_o
);
    logic [NUM_PADS-1:0]  pads_s;
    ch_cfg_t [NUM_CH-1:0] cfg_w;
    logic [NUM_CH-1:0]    reload_w;

    gim_sync #(.W(NUM_PADS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_i),
        .q_o   (pads_s)
    );

    gim_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .cfg_o    (cfg_w),
        .reload_o (reload_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gim_channel #(.NUM_PADS(NUM_PADS)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pads_i   (pads_s),
            .cfg_i    (cfg_w[c]),
            .reload_i (reload_w[c]),
            .irq_o    (irq_o[c])
        );
    end
endmodule

// File: rtl/gim_irq_mux_chk.sv
module gim_irq_mux_chk
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_rdata,
    input  logic [NUM_CH-1:0]    irq_o,
    input  ch_cfg_t [NUM_CH-1:0] cfg,
    input  logic [NUM_CH-1:0]    reload
);
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(reg_addr) > 3) |-> (reg_rdata == 32'h0)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[c] && cfg[c].edge_en && !cfg[c].both_en)
            |=> (!irq_o[c] || !cfg[c].edge_en || cfg[c].both_en)); // R5

        AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(32'(cfg[c].sel) >= NUM_PADS && !cfg[c].inv_en && !cfg[c].both_en
                   && cfg[c].filt == '0)
             && !cfg[c].edge_en && !cfg[c].both_en)
            |-> !irq_o[c]); // R3

        AST_RELOAD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(reload[c]) && (cfg[c].edge_en || cfg[c].both_en))
            |-> !irq_o[c]); // R8
    end
endmodule

bind gim_irq_mux gim_irq_mux_chk #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .cfg       (cfg_w),
    .reload    (reload_w)
);

// File: tb/gim_irq_mux_test.sv
module gim_irq_mux_test;
    localparam int NP = 12;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad_i = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [7:0]    irq_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gim_irq_mux #(.NUM_PADS(NP), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pad_i),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        reg_addr = AW'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input int c, input logic exp);
        chk(req, {31'b0, irq_o[c]}, {31'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        for (int a = 0; a < 4; a++) rd_chk("R1", a, 32'h0);
        chk("R1", {24'b0, irq_o}, 32'h0);

        // R2: readback and unmapped words
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R2", 0, 32'h00FF_FFFF);
        wr(0, 32'h0);
        rd_chk("R2", 0, 32'h0);
        wr(1, 32'hA5C3_0F1E);
        rd_chk("R2", 1, 32'hA5C3_0F1E);
        wr(2, 32'h1234_5678);
        rd_chk("R2", 2, 32'h1234_5678);
        wr(3, 32'h89AB_CDEF);
        rd_chk("R2", 3, 32'h89AB_CDEF);
        for (int a = 4; a < 8; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd_chk("R2", a, 32'h0);
        end
        rd_chk("R2", 3, 32'h89AB_CDEF);
        wr(3, 32'h0);
        wr(1, 32'h0);
        wr(2, 32'h0);
        tick(4);

        // R3/R4: sweep every channel over every pad index, valid and not
        for (int c = 0; c < 8; c++) begin
            for (int idx = 0; idx < 16; idx++) begin
                logic [NP-1:0] oh;
                oh = (idx < NP) ? (NP'(1) << idx) : '0;
                pad_i = oh;
                tick(3);
                wr((c < 4) ? 1 : 2, 32'(idx) << ((c % 4) * 8));
                tick(1);
                irq_chk("R3", c, idx < NP);
                pad_i = ~oh;
                tick(3);
                irq_chk("R3", c, 1'b0);
            end
            wr((c < 4) ? 1 : 2, 32'h0);
        end
        wr(1, 32'h0302_0100);
        wr(2, 32'h0706_0504);
        pad_i = '0;
        tick(4);

        // R4: inversion and latency
        wr(0, 32'h1 << (16 + 2));
        tick(1);
        irq_chk("R4", 2, 1'b1);
        pad_i[2] = 1'b1;
        tick(3);
        irq_chk("R4", 2, 1'b0);
        pad_i[2] = 1'b0;
        tick(2);
        irq_chk("R4", 2, 1'b0);
        tick(1);
        irq_chk("R4", 2, 1'b1);

        // R5: rising edge pulse
        wr(0, 32'h1 << 1);
        tick(2);
        pad_i[1] = 1'b1;
        tick(2);
        irq_chk("R5", 1, 1'b0);
        tick(1);
        irq_chk("R5", 1, 1'b1);
        tick(1);
        irq_chk("R5", 1, 1'b0);
        tick(2);
        irq_chk("R5", 1, 1'b0);
        pad_i[1] = 1'b0;
        tick(3);
        irq_chk("R5", 1, 1'b0);
        tick(1);
        irq_chk("R5", 1, 1'b0);
        // R5: falling edge via inversion
        wr(0, (32'h1 << 1) | (32'h1 << 17));
        tick(1);
        irq_chk("R5", 1, 1'b0);
        pad_i[1] = 1'b1;
        tick(3);
        irq_chk("R5", 1, 1'b0);
        tick(1);
        irq_chk("R5", 1, 1'b0);
        pad_i[1] = 1'b0;
        tick(3);
        irq_chk("R5", 1, 1'b1);
        tick(1);
        irq_chk("R5", 1, 1'b0);

        // R6: both edges, overriding edge and inversion bits
        wr(0, (32'h1 << 5) | (32'h1 << 13) | (32'h1 << 21));
        tick(2);
        irq_chk("R6", 5, 1'b0);
        pad_i[5] = 1'b1;
        tick(3);
        irq_chk("R6", 5, 1'b1);
        tick(1);
        irq_chk("R6", 5, 1'b0);
        pad_i[5] = 1'b0;
        tick(3);
        irq_chk("R6", 5, 1'b1);
        tick(1);
        irq_chk("R6", 5, 1'b0);

        // R7: filter
        wr(0, 32'h0);
        wr(3, 32'h1 << 24);
        tick(3);
        irq_chk("R7", 6, 1'b0);
        pad_i[6] = 1'b1;
        tick(3);
        pad_i[6] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            irq_chk("R7", 6, 1'b0);
        end
        pad_i[6] = 1'b1;
        tick(5);
        irq_chk("R7", 6, 1'b0);
        tick(1);
        irq_chk("R7", 6, 1'b1);
        wr(3, 32'h2 << 24);
        tick(2);
        pad_i[6] = 1'b0;
        tick(9);
        irq_chk("R7", 6, 1'b1);
        tick(1);
        irq_chk("R7", 6, 1'b0);
        wr(3, 32'h0);

        // R8: reprogramming without spurious pulses
        wr(0, 32'h1);
        pad_i[3] = 1'b1;
        pad_i[0] = 1'b0;
        tick(4);
        wr(1, 32'h0302_0103);
        for (int i = 0; i < 4; i++) begin
            irq_chk("R8", 0, 1'b0);
            tick(1);
        end
        pad_i[4] = 1'b1;
        tick(4);
        irq_chk("R4", 4, 1'b1);
        wr(0, 32'h11);
        for (int i = 0; i < 3; i++) begin
            tick(1);
            irq_chk("R8", 4, 1'b0);
        end
        wr(0, 32'h1001);
        for (int i = 0; i < 3; i++) begin
            tick(1);
            irq_chk("R8", 4, 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule